// File: doc/BRIEF.md
# Down-Link Master-Abort Responder

This block sits in front of a downstream port and watches every request that the local processor sends toward it. While the port's link is up, requests flow straight through to the link side with their handshake untouched. While the link is down, or nothing is attached, requests never reach the link. The block accepts them itself and finishes them locally, the way a master abort is handled. Bus enumeration that probes empty slots can then run to completion without hanging and without side effects.

A single configuration input selects how these local completions look. In unsupported-request mode, every non-posted request gets a completion with the unsupported-request status. In benign mode, reads return a word of all ones with a successful status, and non-posted writes get a plain successful completion. Posted writes to a down link are discarded in either mode. Each local completion carries the tag of its request and sits in a one-entry response register until the consumer takes it.

Top module: `dl_abort_responder`

## Requirements
- R1: While `link_up` is low, `fwd_valid` stays low and requests are accepted locally through `req_ready`.
- R2: With `cfg_benign` low, a non-posted request accepted on a down link yields a response with status 2'b01 (unsupported request) and read data zero.
- R3: With `cfg_benign` high, a read (`req_write` low) accepted on a down link yields status 2'b00 (successful) and read data 32'hFFFF_FFFF.
- R4: With `cfg_benign` high, a non-posted write accepted on a down link yields status 2'b00 and read data zero.
- R5: A posted write (`req_posted` and `req_write` both high) accepted on a down link produces no response in either mode. A read is always treated as non-posted.
- R6: While `link_up` is high, `fwd_valid`, `fwd_posted`, `fwd_write` and `fwd_tag` follow the request inputs in the same cycle, `req_ready` equals `fwd_ready`, and no new local response is created.
- R7: A local response is raised in the cycle after the accepting clock edge and carries the accepted request's tag.
- R8: A response is held with stable tag, status and data until `rsp_ready` is high. On a down link `req_ready` is high when no response is pending or when the pending one is taken in the same cycle, so back-to-back requests are accepted.
- R9: The mode is captured when a request is accepted. Changing `cfg_benign` while that response is pending does not alter it.
- R10: After synchronous reset, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_benign | input | 1 | 1: all-ones/successful completions; 0: unsupported-request completions |
| link_up | input | 1 | Downstream link is up and a device is attached |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (link side when up, local when down) |
| req_posted | input | 1 | Request is posted |
| req_write | input | 1 | 1 write, 0 read |
| req_tag | input | TAG_W | Request tag |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Link side can accept |
| fwd_posted | output | 1 | Forwarded posted flag |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_tag | output | TAG_W | Forwarded tag |
| rsp_valid | output | 1 | Local response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_tag | output | TAG_W | Tag of the completed request |
| rsp_status | output | 2 | 2'b00 successful, 2'b01 unsupported request |
| rsp_rdata | output | DATA_W | Read data of the local completion |

## Verification
The only state in the block is the pending-response register. If it is wrong, the effect shows at the ports within one cycle of an acceptance. It can be a lost or extra `rsp_valid`, a tag or status that changes while the response is held, or a `req_ready` that blocks or admits a request at the wrong time. The bench drives directed cases and a long stretch of mixed traffic, including link flaps with a response pending and mode flips during a hold. Its reference model is compared with every output on every cycle, so a fault is reported in the cycle it first appears.

// File: rtl/dlar_pkg.sv
package dlar_pkg;

    localparam int unsigned DEF_TAG_W  = 8;
    localparam int unsigned DEF_DATA_W = 32;

    typedef enum logic [1:0] {
        CPL_SC = 2'b00,
        CPL_UR = 2'b01
    } cpl_status_e;

    // Only a posted write finishes without any completion.
    function automatic logic needs_response(input logic posted, input logic write);
        return !(posted && write);
    endfunction

    function automatic cpl_status_e pick_status(input logic benign);
        return benign ? CPL_SC : CPL_UR;
    endfunction

    function automatic logic fill_ones(input logic benign, input logic write);
        return benign && !write;
    endfunction

endpackage

// File: rtl/dlar_route.sv
module dlar_route #(
    parameter int unsigned TAG_W = dlar_pkg::DEF_TAG_W
) (
    input  logic             link_up,
    input  logic             slot_free,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_posted,
    input  logic             req_write,
    input  logic [TAG_W-1:0] req_tag,
    output logic             fwd_valid,
    input  logic             fwd_ready,
    output logic             fwd_posted,
    output logic             fwd_write,
    output logic [TAG_W-1:0] fwd_tag,
    output logic             local_acc
);

    always_comb begin
        fwd_posted = req_posted;
        fwd_write  = req_write;
        fwd_tag    = req_tag;
        if (link_up) begin
            fwd_valid = req_valid;
            req_ready = fwd_ready;
            local_acc = 1'b0;
        end else begin
            fwd_valid = 1'b0;
            req_ready = slot_free;
            local_acc = req_valid && slot_free;
        end
    end

endmodule

// File: rtl/dlar_rsp_gen.sv
module dlar_rsp_gen
    import dlar_pkg::*;
#(
    parameter int unsigned TAG_W  = DEF_TAG_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_benign,
    input  logic              local_acc,
    input  logic              req_posted,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              slot_free
);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        cpl_status_e       status;
        logic [DATA_W-1:0] data;
    } cpl_t;

    cpl_t cpl_q;
    cpl_t cpl_d;
    logic valid_q;
    logic want_rsp;

    assign want_rsp  = local_acc && needs_response(req_posted, req_write);
    assign slot_free = !valid_q || rsp_ready;

    always_comb begin
        cpl_d.tag    = req_tag;
        cpl_d.status = pick_status(cfg_benign);
        cpl_d.data   = fill_ones(cfg_benign, req_write) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cpl_q   <= '0;
        end else begin
            if (valid_q && rsp_ready) begin
                valid_q <= 1'b0;
            end
            if (want_rsp) begin
                valid_q <= 1'b1;
                cpl_q   <= cpl_d;
            end
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_tag    = cpl_q.tag;
    assign rsp_status = cpl_q.status;
    assign rsp_rdata  = cpl_q.data;

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_status) && $stable(rsp_rdata))); // R8

    AST_RSP_TAG: assert property (@(posedge clk) disable iff (rst)
        (local_acc && !(req_posted && req_write)) |=> (rsp_valid && rsp_tag == $past(req_tag))); // R7

    AST_UR_MODE: assert property (@(posedge clk) disable iff (rst)
        (local_acc && !(req_posted && req_write) && !cfg_benign) |=> (rsp_status == 2'b01 && rsp_rdata == '0)); // R2

    AST_BENIGN_READ: assert property (@(posedge clk) disable iff (rst)
        (local_acc && !req_write && cfg_benign) |=> (rsp_status == 2'b00 && rsp_rdata == '1)); // R3

    AST_BENIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (local_acc && req_write && !req_posted && cfg_benign) |=> (rsp_status == 2'b00 && rsp_rdata == '0)); // R4

    AST_POSTED_DROP: assert property (@(posedge clk) disable iff (rst)
        (local_acc && req_posted && req_write) |=> !rsp_valid); // R5

endmodule

// File: rtl/dl_abort_responder.sv
module dl_abort_responder
    import dlar_pkg::*;
#(
    parameter int unsigned TAG_W  = DEF_TAG_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_benign,
    input  logic              link_up,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_posted,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic              fwd_posted,
    output logic              fwd_write,
    output logic [TAG_W-1:0]  fwd_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic slot_free;
    logic local_acc;

    dlar_route #(.TAG_W(TAG_W)) u_route (
        .link_up    (link_up),
        .slot_free  (slot_free),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_posted (req_posted),
        .req_write  (req_write),
        .req_tag    (req_tag),
        .fwd_valid  (fwd_valid),
        .fwd_ready  (fwd_ready),
        .fwd_posted (fwd_posted),
        .fwd_write  (fwd_write),
        .fwd_tag    (fwd_tag),
        .local_acc  (local_acc)
    );

    dlar_rsp_gen #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_rsp (
        .clk        (clk),
        .rst        (rst),
        .cfg_benign (cfg_benign),
        .local_acc  (local_acc),
        .req_posted (req_posted),
        .req_write  (req_write),
        .req_tag    (req_tag),
        .rsp_ready  (rsp_ready),
        .rsp_valid  (rsp_valid),
        .rsp_tag    (rsp_tag),
        .rsp_status (rsp_status),
        .rsp_rdata  (rsp_rdata),
        .slot_free  (slot_free)
    );

    AST_NO_LOCAL_WHEN_UP: assert property (@(posedge clk) disable iff (rst)
        (link_up && !rsp_valid) |=> !rsp_valid); // R6

    AST_DOWN_NOT_SENT: assert property (@(posedge clk) disable iff (rst)
        (!link_up && req_valid && req_ready && !(req_posted && req_write)) |=> rsp_valid); // R1

endmodule

// File: tb/tb_dl_abort_responder.sv
`timescale 1ns/1ps
module tb_dl_abort_responder;

    localparam int TW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_benign = 1'b0, link_up = 1'b0;
    logic req_valid = 1'b0, req_posted = 1'b0, req_write = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic fwd_ready = 1'b0, rsp_ready = 1'b0;
    logic req_ready, fwd_valid, fwd_posted, fwd_write, rsp_valid;
    logic [TW-1:0] fwd_tag, rsp_tag;
    logic [1:0] rsp_status;
    logic [DW-1:0] rsp_rdata;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state
    bit m_rv = 0;
    int m_tag = 0;
    int m_st = 0;
    logic [DW-1:0] m_rd = '0;

    always #5 clk = ~clk;

    dl_abort_responder #(.TAG_W(TW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .cfg_benign(cfg_benign), .link_up(link_up),
        .req_valid(req_valid), .req_ready(req_ready), .req_posted(req_posted),
        .req_write(req_write), .req_tag(req_tag), .fwd_valid(fwd_valid),
        .fwd_ready(fwd_ready), .fwd_posted(fwd_posted), .fwd_write(fwd_write),
        .fwd_tag(fwd_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_tag(rsp_tag), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        bit e_ready;
        e_ready = link_up ? fwd_ready : (!m_rv || rsp_ready);
        chk(req_ready == e_ready, link_up ? "R6 req_ready" : "R8 req_ready", req_ready, e_ready);
        chk(fwd_valid == (link_up && req_valid), link_up ? "R6 fwd_valid" : "R1 fwd_valid",
            fwd_valid, link_up && req_valid);
        if (link_up && req_valid) begin
            chk({fwd_posted, fwd_write, fwd_tag} == {req_posted, req_write, req_tag}, "R6 fwd fields",
                {fwd_posted, fwd_write, fwd_tag}, {req_posted, req_write, req_tag});
        end
        chk(rsp_valid == m_rv, "R5/R7 rsp_valid", rsp_valid, m_rv);
        if (m_rv && rsp_valid) begin
            chk(rsp_tag == m_tag[TW-1:0], "R7 rsp_tag", rsp_tag, m_tag);
            chk(rsp_status == m_st[1:0], m_st == 1 ? "R2 status" : "R4 status", rsp_status, m_st);
            chk(rsp_rdata == m_rd, "R3 rdata", rsp_rdata, m_rd);
        end
    endtask

    task automatic model_edge();
        bit e_ready, acc;
        e_ready = link_up ? fwd_ready : (!m_rv || rsp_ready);
        if (rst) begin
            m_rv = 0;
        end else begin
            acc = req_valid && e_ready && !link_up;
            if (m_rv && rsp_ready) m_rv = 0;
            if (acc && !(req_posted && req_write)) begin
                m_rv  = 1;
                m_tag = req_tag;
                m_st  = cfg_benign ? 0 : 1;
                m_rd  = (cfg_benign && !req_write) ? 32'hFFFF_FFFF : 32'h0;
            end
        end
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
    endtask

    task automatic drive(input bit lu, input bit bn, input bit v, input bit p, input bit w,
                         input int tag, input bit fr, input bit rr);
        link_up = lu; cfg_benign = bn; req_valid = v; req_posted = p; req_write = w;
        req_tag = tag[TW-1:0]; fwd_ready = fr; rsp_ready = rr;
        step();
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 3, 0, 0);
        #1;
        chk(rsp_valid == 1'b0, "R10 reset rsp_valid", rsp_valid, 0);
        rst = 1'b0;

        // R2: unsupported-request mode, non-posted read and write
        drive(0, 0, 1, 0, 0, 8'h11, 0, 0);
        #1; chk(rsp_status == 2'b01, "R2 read UR", rsp_status, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        drive(0, 0, 1, 0, 1, 8'h12, 0, 1);
        #1; chk(rsp_status == 2'b01 && rsp_rdata == 0, "R2 write UR", rsp_status, 1);
        // R3 benign read, back-to-back with drain (R8)
        drive(0, 1, 1, 0, 0, 8'h21, 0, 1);
        #1; chk(rsp_rdata == 32'hFFFF_FFFF, "R3 all ones", rsp_rdata, 32'hFFFF_FFFF);
        // R4 benign non-posted write
        drive(0, 1, 1, 0, 1, 8'h22, 0, 1);
        #1; chk(rsp_status == 2'b00 && rsp_rdata == 0, "R4 write SC", rsp_status, 0);
        drive(0, 1, 0, 0, 0, 0, 0, 1);
        // R5 posted write dropped in both modes
        drive(0, 1, 1, 1, 1, 8'h31, 0, 1);
        #1; chk(rsp_valid == 0, "R5 benign posted drop", rsp_valid, 0);
        drive(0, 0, 1, 1, 1, 8'h32, 0, 1);
        #1; chk(rsp_valid == 0, "R5 UR posted drop", rsp_valid, 0);
        // posted read still answered
        drive(0, 1, 1, 1, 0, 8'h33, 0, 0);
        #1; chk(rsp_valid == 1 && rsp_tag == 8'h33, "R5 posted read answered", rsp_tag, 8'h33);
        // R9: hold with mode flips, mode captured at acceptance
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        drive(0, 0, 1, 0, 0, 8'h44, 0, 0);
        drive(0, 1, 1, 0, 0, 8'h45, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0, 0);
        #1; chk(rsp_status == 2'b01 && rsp_tag == 8'h44, "R9 mode held", rsp_status, 1);
        drive(0, 1, 0, 0, 0, 0, 0, 1);
        // R6 link up: pass-through, no local response
        drive(1, 0, 1, 0, 0, 8'h55, 1, 1);
        drive(1, 1, 1, 1, 1, 8'h56, 0, 1);
        #1; chk(rsp_valid == 0 && fwd_tag == 8'h56, "R6 no local rsp", rsp_valid, 0);
        // pending response across a link flap
        drive(0, 1, 1, 0, 0, 8'h66, 0, 0);
        drive(1, 1, 1, 0, 0, 8'h67, 1, 0);
        drive(1, 1, 0, 0, 0, 0, 1, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1);

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 4) == 0, $urandom % 2, ($urandom % 4) != 0, $urandom % 2,
                  $urandom % 2, $urandom % 256, $urandom % 2, ($urandom % 3) != 0);
            if ((i % 500) == 250) begin
                rst = 1'b1;
                drive(0, 0, 0, 0, 0, 0, 0, 0);
                #1; chk(rsp_valid == 0, "R10 mid reset", rsp_valid, 0);
                rst = 1'b0;
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule